// File: doc/BRIEF.md
# Programmable-Format Serial Character Transmitter

This block turns one parallel character at a time into an asynchronous serial frame on a single TX line. Software or an upstream queue writes a byte through a valid/ready handshake into a one-entry holding register. When the shifter is idle it takes the byte from there and sends a frame. The frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then a stop period. The line rests high between frames.

The frame format comes from an 8-bit control byte. The control byte is captured when each frame begins, so later changes apply only to the next frame. Bit timing comes from an external enable pulse that runs at sixteen times the baud rate. The block contains no divisor of its own. Two flags show the queue state. One shows that the holding register can accept a byte. The other shows that nothing is held and nothing is being shifted.

Top module: `uart_frame_tx`

## Requirements
- R1: Control bits [1:0] set the number of data bits: 00 sends 5, 01 sends 6, 10 sends 7 and 11 sends 8. Only the low bits of the byte are sent.
- R2: The TX line is high at rest. Every frame begins with one low start bit, and data bits follow with bit 0 first.
- R3: When control bit [3] is 0, no parity bit is sent, whatever bits [5:4] hold.
- R4: When control bit [3] is 1, bits [5:4] = 00 give odd parity and 01 gives even parity, counted over the data bits that are sent.
- R5: When control bit [3] is 1, bits [5:4] = 10 send a parity bit fixed at 1 and 11 send one fixed at 0, whatever the data.
- R6: When control bit [2] is 0, the stop period is one bit (16 ticks) at every word length.
- R7: When control bit [2] is 1, the stop period is 24 ticks for 5-bit words and 32 ticks for 6, 7 and 8-bit words.
- R8: The start bit, each data bit and the parity bit each last exactly 16 baud ticks.
- R9: The control byte is sampled when a frame begins. Changing it during a frame does not alter that frame.
- R10: ready_o and hold_empty_o are 1 while the holding register is free. An accepted byte clears them until the shifter takes the byte. Valid data offered while the register is full is ignored.
- R11: tx_empty_o is 1 only when the holding register is free and no frame is in progress.
- R12: After reset, tx_o, ready_o, hold_empty_o and tx_empty_o are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | One-cycle pulse at 16x the baud rate |
| ctrl_i | input | 8 | Frame format control byte |
| data_i | input | 8 | Character to send |
| valid_i | input | 1 | data_i is offered |
| ready_o | output | 1 | Holding register can accept data_i |
| tx_o | output | 1 | Serial output, idle high |
| hold_empty_o | output | 1 | Holding register is empty |
| tx_empty_o | output | 1 | Holding register and shifter are both empty |

## Verification
Some properties are checked on every cycle. The per-bit tick counter must stay inside the length of its current bit. The latched frame format must not change while a frame is running. The holding register must keep its byte until the shifter takes it. The line must be low in the first cycle of a new frame and high whenever the transmitter is fully empty. Other behaviour can only be shown by the bench scenarios, which decode whole frames at the pin. These cover bit order, word length, the parity value in each mode, the 16-, 24- and 32-tick stop periods, and that a control change in mid-frame has no effect.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_START = 3'd1,
    PH_DATA  = 3'd2,
    PH_PAR   = 3'd3,
    PH_STOP  = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    PAR_ODD   = 2'b00,
    PAR_EVEN  = 2'b01,
    PAR_MARK  = 2'b10,
    PAR_SPACE = 2'b11
  } par_mode_e;
endpackage

// File: rtl/uart_tx_fmt.sv
module uart_tx_fmt
  import uart_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVS    = 16
) (
  input  logic [7:0]        ctrl_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [3:0]        nbits_o,
  output logic              par_en_o,
  output logic              par_bit_o,
  output logic [$clog2(2*OVS+1)-1:0] stop_ticks_o
);
  localparam int unsigned CNT_W = $clog2(2*OVS+1);
  localparam logic [CNT_W-1:0] STOP_1  = CNT_W'(OVS);
  localparam logic [CNT_W-1:0] STOP_15 = CNT_W'(OVS + OVS/2);
  localparam logic [CNT_W-1:0] STOP_2  = CNT_W'(2*OVS);

  logic [DATA_W-1:0] masked;
  logic              xor_all;
  par_mode_e         mode;

  assign nbits_o  = 4'd5 + {2'b00, ctrl_i[1:0]};
  assign par_en_o = ctrl_i[3];
  assign mode     = par_mode_e'(ctrl_i[5:4]);

  always_comb begin
    for (int i = 0; i < DATA_W; i++) masked[i] = data_i[i] & (i < int'(nbits_o));
  end
  assign xor_all = ^masked;

  always_comb begin
    unique case (mode)
      PAR_ODD:   par_bit_o = ~xor_all;
      PAR_EVEN:  par_bit_o = xor_all;
      PAR_MARK:  par_bit_o = 1'b1;
      default:   par_bit_o = 1'b0;
    endcase
  end

  always_comb begin
    if (!ctrl_i[2])                stop_ticks_o = STOP_1;
    else if (ctrl_i[1:0] == 2'b00) stop_ticks_o = STOP_15;
    else                           stop_ticks_o = STOP_2;
  end
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic              pop_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o
);
  logic [DATA_W-1:0] data_q;
  logic              full_q;
  logic              push;

  assign ready_o = ~full_q;
  assign push    = valid_i & ~full_q;
  assign data_o  = data_q;
  assign full_o  = full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (push) data_q <= data_i;
      full_q <= push | (full_q & ~pop_i);
    end
  end

  assert_push_fills_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_o |=> full_q && (data_q == $past(data_i)));
  assert_hold_kept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q && !pop_i |=> full_q && $stable(data_q));
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              avail_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [3:0]        nbits_i,
  input  logic              par_en_i,
  input  logic              par_bit_i,
  input  logic [$clog2(2*OVS+1)-1:0] stop_ticks_i,
  output logic              pop_o,
  output logic              idle_o,
  output logic              tx_o
);
  localparam int unsigned CNT_W = $clog2(2*OVS+1);
  localparam logic [CNT_W-1:0] BIT_TICKS = CNT_W'(OVS);

  phase_e            phase_q;
  logic [CNT_W-1:0]  cnt_q, limit;
  logic [3:0]        idx_q, nbits_q;
  logic [DATA_W-1:0] sh_q;
  logic              par_en_q, par_q;
  logic [CNT_W-1:0]  stop_q;
  logic              bit_end;

  assign idle_o  = (phase_q == PH_IDLE);
  assign pop_o   = idle_o & avail_i;
  assign limit   = (phase_q == PH_STOP) ? stop_q : BIT_TICKS;
  assign bit_end = tick_i && (cnt_q == limit - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      idx_q    <= '0;
      sh_q     <= '0;
      nbits_q  <= 4'd5;
      par_en_q <= 1'b0;
      par_q    <= 1'b0;
      stop_q   <= BIT_TICKS;
    end else if (pop_o) begin
      // frame start: capture data and format together
      phase_q  <= PH_START;
      cnt_q    <= '0;
      idx_q    <= '0;
      sh_q     <= data_i;
      nbits_q  <= nbits_i;
      par_en_q <= par_en_i;
      par_q    <= par_bit_i;
      stop_q   <= stop_ticks_i;
    end else if (!idle_o && tick_i) begin
      if (!bit_end) begin
        cnt_q <= cnt_q + 1'b1;
      end else begin
        cnt_q <= '0;
        unique case (phase_q)
          PH_START: phase_q <= PH_DATA;
          PH_DATA: begin
            sh_q  <= sh_q >> 1;
            idx_q <= idx_q + 4'd1;
            if (idx_q == nbits_q - 4'd1) phase_q <= par_en_q ? PH_PAR : PH_STOP;
          end
          PH_PAR:  phase_q <= PH_STOP;
          default: phase_q <= PH_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    unique case (phase_q)
      PH_START: tx_o = 1'b0;
      PH_DATA:  tx_o = sh_q[0];
      PH_PAR:   tx_o = par_q;
      default:  tx_o = 1'b1;
    endcase
  end

  assert_cnt_in_bit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_o |-> cnt_q < limit);
  assert_fmt_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_o && $past(!idle_o) |->
      $stable(nbits_q) && $stable(par_en_q) && $stable(par_q) && $stable(stop_q));
  assert_idx_bounded_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_DATA |-> idx_q < nbits_q);
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              baud_tick_i,
  input  logic [7:0]        ctrl_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              tx_o,
  output logic              hold_empty_o,
  output logic              tx_empty_o
);
  localparam int unsigned CNT_W = $clog2(2*OVS+1);

  logic [DATA_W-1:0] hold_data;
  logic              hold_full, pop, idle;
  logic [3:0]        nbits;
  logic              par_en, par_bit;
  logic [CNT_W-1:0]  stop_ticks;

  uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i, .rst_ni, .data_i, .valid_i, .ready_o,
    .pop_i(pop), .data_o(hold_data), .full_o(hold_full)
  );

  uart_tx_fmt #(.DATA_W(DATA_W), .OVS(OVS)) u_fmt (
    .ctrl_i, .data_i(hold_data), .nbits_o(nbits), .par_en_o(par_en),
    .par_bit_o(par_bit), .stop_ticks_o(stop_ticks)
  );

  uart_tx_shift #(.DATA_W(DATA_W), .OVS(OVS)) u_shift (
    .clk_i, .rst_ni, .tick_i(baud_tick_i), .avail_i(hold_full),
    .data_i(hold_data), .nbits_i(nbits), .par_en_i(par_en), .par_bit_i(par_bit),
    .stop_ticks_i(stop_ticks), .pop_o(pop), .idle_o(idle), .tx_o
  );

  assign hold_empty_o = ~hold_full;
  assign tx_empty_o   = ~hold_full & idle;

  assert_frame_starts_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(idle) |-> !tx_o);
  assert_empty_line_high_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> tx_o);
endmodule

// File: tb/uart_frame_tx_test.sv
module uart_frame_tx_test;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, valid = 1'b0;
  logic [7:0] ctrl = 8'h03, data = 8'h00;
  logic ready, tx, hold_empty, tx_empty;
  int vectors = 0, miscompares = 0, cyc = 0;
  int mon_cnt = 0, frames_done = 0;
  bit in_frame = 1'b0;
  logic rec [0:255];

  uart_frame_tx uut (
    .clk_i(clk), .rst_ni(rst_n), .baud_tick_i(tick), .ctrl_i(ctrl), .data_i(data),
    .valid_i(valid), .ready_o(ready), .tx_o(tx), .hold_empty_o(hold_empty),
    .tx_empty_o(tx_empty)
  );

  always #2 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) tick <= 1'b0; else tick <= ~tick;

  // records line level at each tick of a frame in progress with an empty holding register
  always @(negedge clk) begin
    if (!tx_empty && hold_empty) begin
      if (!in_frame) begin in_frame = 1'b1; mon_cnt = 0; end
      if (tick && mon_cnt < 256) begin rec[mon_cnt] = tx; mon_cnt++; end
    end else if (in_frame) begin
      in_frame = 1'b0;
      frames_done++;
    end
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      miscompares++;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_frame(input logic [7:0] d, input logic [7:0] c, input string req);
    int n, pe, stop, total, got, expd;
    logic p;
    n     = 5 + int'(c[1:0]);
    pe    = c[3] ? 1 : 0;
    stop  = !c[2] ? 16 : (n == 5 ? 24 : 32);
    total = 16 * (1 + n + pe) + stop;
    expd  = int'(d) & ((1 << n) - 1);
    got   = 0;
    for (int i = 0; i < n; i++) got |= int'(rec[16*(1+i)+8]) << i;
    chk(mon_cnt == total, req, "frame ticks", mon_cnt, total);
    chk(rec[8] == 1'b0, req, "start bit", int'(rec[8]), 0);
    chk(got == expd, req, "data bits", got, expd);
    if (pe == 1) begin
      case (c[5:4])
        2'b00: p = ~(^expd[7:0]);
        2'b01: p = ^expd[7:0];
        2'b10: p = 1'b1;
        default: p = 1'b0;
      endcase
      chk(rec[16*(1+n)+8] == p, req, "parity bit", int'(rec[16*(1+n)+8]), int'(p));
    end
    chk(rec[16*(1+n+pe)+8] == 1'b1 && rec[total-1] == 1'b1, req, "stop level",
        int'(rec[total-1]), 1);
  endtask

  task automatic send(input logic [7:0] d, input logic [7:0] c, input logic [7:0] c_mid,
                      input string req);
    int fd0;
    @(negedge clk);
    while (!tx_empty) @(negedge clk);
    fd0 = frames_done;
    data = d; ctrl = c; valid = 1'b1;
    @(negedge clk); valid = 1'b0;
    @(negedge clk); ctrl = c_mid;
    wait (frames_done != fd0);
    @(negedge clk);
    check_frame(d, c, req);
  endtask

  task automatic t_reset();
    chk(tx == 1'b1, "R12", "tx after reset", int'(tx), 1);
    chk(ready == 1'b1, "R12", "ready after reset", int'(ready), 1);
    chk(hold_empty == 1'b1, "R12", "hold_empty after reset", int'(hold_empty), 1);
    chk(tx_empty == 1'b1, "R12", "tx_empty after reset", int'(tx_empty), 1);
  endtask

  task automatic t_lengths();
    send(8'hB5, 8'h00, 8'h00, "R1");
    send(8'h6A, 8'h01, 8'h01, "R1");
    send(8'hD3, 8'h02, 8'h02, "R2");
    send(8'h81, 8'h03, 8'h03, "R8");
    send(8'h4E, 8'h03, 8'h03, "R6");
  endtask

  task automatic t_parity();
    send(8'h07, 8'h08, 8'h08, "R4");  // 5-bit odd
    send(8'h16, 8'h08, 8'h08, "R4");
    send(8'hA5, 8'h1B, 8'h1B, "R4");  // 8-bit even
    send(8'hA4, 8'h1B, 8'h1B, "R4");
    send(8'hFF, 8'h0B, 8'h0B, "R4");  // 8-bit odd
    send(8'h5A, 8'h33, 8'h33, "R3");  // parity disabled, mode bits set
  endtask

  task automatic t_forced();
    send(8'h00, 8'h2B, 8'h2B, "R5");
    send(8'hFF, 8'h2B, 8'h2B, "R5");
    send(8'hFF, 8'h3B, 8'h3B, "R5");
    send(8'h00, 8'h3A, 8'h3A, "R5");
  endtask

  task automatic t_stop();
    send(8'h15, 8'h04, 8'h04, "R7");  // 5-bit, 24 ticks
    send(8'h2A, 8'h05, 8'h05, "R7");  // 6-bit, 32 ticks
    send(8'hC7, 8'h07, 8'h07, "R7");
    send(8'h0F, 8'h0C, 8'h0C, "R7");  // 5-bit odd, 24 ticks
  endtask

  task automatic t_sample();
    send(8'hA5, 8'h03, 8'h3C, "R9");
    send(8'h1E, 8'h0C, 8'h03, "R9");
  endtask

  task automatic t_handshake();
    int fd0;
    @(negedge clk);
    while (!tx_empty) @(negedge clk);
    data = 8'h3C; ctrl = 8'h03; valid = 1'b1;
    @(negedge clk); valid = 1'b0;
    chk(hold_empty == 1'b0 && ready == 1'b0, "R10", "held byte clears ready", int'(ready), 0);
    chk(tx_empty == 1'b0, "R11", "tx_empty with byte held", int'(tx_empty), 0);
    @(negedge clk);
    chk(hold_empty == 1'b1, "R10", "hold_empty after take", int'(hold_empty), 1);
    chk(tx_empty == 1'b0, "R11", "tx_empty while shifting", int'(tx_empty), 0);
    data = 8'hC3; valid = 1'b1;
    @(negedge clk);
    data = 8'h55;
    for (int i = 0; i < 10; i++) @(negedge clk);
    valid = 1'b0;
    chk(ready == 1'b0 && hold_empty == 1'b0, "R10", "full register blocks", int'(ready), 0);
    chk(tx_empty == 1'b0, "R11", "tx_empty with both busy", int'(tx_empty), 0);
    while (!hold_empty) @(negedge clk);
    fd0 = frames_done;
    wait (frames_done != fd0);
    @(negedge clk);
    check_frame(8'hC3, 8'h03, "R10");
    chk(tx_empty == 1'b1 && hold_empty == 1'b1, "R11", "both empty at end", int'(tx_empty), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_lengths();
    t_parity();
    t_forced();
    t_stop();
    t_sample();
    t_handshake();
    summary();
  end
endmodule